// File: doc/BRIEF.md
# Passive I2C Bus Monitor

This block watches a two-wire I2C bus and reports what it sees, without ever taking part in the traffic. Both lines enter through a two-stage synchroniser and a short glitch filter. All timing is taken from a system clock that runs at least sixteen times faster than SCL. The filtered levels are compared with their values one cycle earlier, which yields three events: START (SDA falls while SCL is high), STOP (SDA rises while SCL is high) and a rising edge of SCL.

During a transfer, each SCL rising edge shifts one SDA bit into a 9-bit frame. The frame holds eight address or data bits followed by the acknowledge bit. A finished frame leaves the block as a one-cycle strobe with tags:
- first frame after a START;
- acknowledged;
- 10-bit address header;
- low address byte that follows such a header.

START, repeated START and STOP are each reported with their own one-cycle strobe and a kind code. Every START or STOP clears the bit counter at once. So a STOP followed at once by a new START can never move the frame boundary, and the stray bit that the SCL rise before a STOP or repeated START leaves behind is thrown away.

The two bus-drive outputs are tied released. The monitor sends no acknowledge and never stretches the clock.

Top module: `i2c_listen_monitor`

## Requirements
- R1: `scl_drive_low` and `sda_drive_low` are 0 at all times, including during reset.
- R2: A filtered SDA fall while SCL is high gives a one-cycle `cond_pulse`. `cond_kind` is 1 (START) when the bus was idle and 2 (repeated START) when a transfer was already open. A filtered SDA rise while SCL is high gives `cond_pulse` with `cond_kind` 3 (STOP) and closes the transfer.
- R3: Inside a transfer, SDA is sampled on each filtered SCL rise, most significant bit first. After the ninth sample, `frame_valid` pulses for one cycle. `frame_data[8:1]` then holds the byte and `frame_data[0]` the ninth bit.
- R4: Every START, repeated START or STOP returns the bit counter to zero within the cycle it is detected. The bit sampled by the SCL rise just before the condition is discarded. A frame that follows a STOP and an immediate START is aligned to that START.
- R5: `frame_ack` is 1 exactly when the ninth bit of the frame was low.
- R6: If a START or STOP arrives while two or more bits of an unfinished frame are held, `trunc_err` pulses in the same cycle as that condition's `cond_pulse`, and those bits are dropped without a frame.
- R7: `frame_first` is 1 on the first frame after a START or repeated START. `frame_hdr10` is 1 on such a first frame when `frame_data[8:4]` is 11110. `frame_addr_lo` is 1 on the frame that directly follows a header frame in the same transfer.
- R8: SCL edges while no transfer is open produce no frame and no error.
- R9: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks does not change the filtered level. It produces no bit, no condition and no frame.
- R10: After reset, `cond_pulse`, `cond_kind`, `frame_valid`, `frame_data`, all frame tags and `trunc_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL level from the bus |
| sda_in | input | 1 | Raw SDA level from the bus |
| scl_drive_low | output | 1 | SCL pull-down enable, always 0 |
| sda_drive_low | output | 1 | SDA pull-down enable, always 0 |
| cond_pulse | output | 1 | One-cycle strobe for a START, repeated START or STOP |
| cond_kind | output | 2 | 1 START, 2 repeated START, 3 STOP; 0 otherwise |
| frame_valid | output | 1 | One-cycle strobe for a completed 9-bit frame |
| frame_data | output | 9 | Byte in [8:1], ninth bit in [0] |
| frame_first | output | 1 | Frame is the first after a START |
| frame_ack | output | 1 | Ninth bit was low |
| frame_hdr10 | output | 1 | First frame carries the 10-bit address header pattern |
| frame_addr_lo | output | 1 | Frame follows a 10-bit header frame |
| trunc_err | output | 1 | Partial frame dropped at a START or STOP |

## Verification
The hardest case to reach from the ports is a condition that arrives exactly one SCL rise after a frame boundary. This happens when a STOP is followed straight away by a START, or when a repeated START is issued. In both cases the counter holds one stray bit that must be dropped silently. The bench drives these sequences with a gap between STOP and START only slightly longer than the filter length. It then checks that the following address frames match byte for byte and raise no truncation error.

Sub-filter-length glitches on SCL during its low phase, and on SDA during its high phase, are injected inside real frames. SCL toggling on an idle bus and a four-bit aborted frame cover the remaining cases.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

  localparam int FRAME_BITS = 9;

  typedef enum logic [1:0] {
    COND_NONE    = 2'd0,
    COND_START   = 2'd1,
    COND_RESTART = 2'd2,
    COND_STOP    = 2'd3
  } cond_e;

  // Header pattern of a 10-bit address in the first frame of a transfer
  function automatic logic is_ten_bit_hdr(input logic [FRAME_BITS-1:0] f,
                                          input logic first);
    return first && (f[FRAME_BITS-1 -: 5] == 5'b11110);
  endfunction

  // Acknowledge is signalled by a low level in the last bit slot
  function automatic logic ack_of(input logic [FRAME_BITS-1:0] f);
    return ~f[0];
  endfunction

  // Kind of a START given whether a transfer is already open
  function automatic cond_e start_kind(input logic busy);
    return busy ? COND_RESTART : COND_START;
  endfunction

endpackage

// File: rtl/mon_line_filter.sv
module mon_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_out
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1, s2;
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1       <= 1'b1;
      s2       <= 1'b1;
      run      <= '0;
      line_out <= 1'b1;
    end else begin
      s1 <= line_in;
      s2 <= s1;
      if (s2 == line_out) begin
        run <= '0;
      end else if (run == CW'(FILT_LEN - 1)) begin
        line_out <= s2;
        run      <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mon_cond_detect.sv
module mon_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  logic scl_held_high;
  assign scl_held_high = scl_f & scl_p;

  assign ev_start = scl_held_high & sda_p & ~sda_f;
  assign ev_stop  = scl_held_high & ~sda_p & sda_f;
  assign ev_rise  = scl_f & ~scl_p;
endmodule

// File: rtl/mon_frame_shifter.sv
module mon_frame_shifter #(
  parameter int FRAME_BITS = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ev_rise,
  input  logic                  ev_cond,
  input  logic                  active,
  input  logic                  sda_f,
  output logic                  frame_valid,
  output logic [FRAME_BITS-1:0] frame_data,
  output logic [$clog2(FRAME_BITS+1)-1:0] bit_cnt,
  output logic                  trunc_err
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] shreg;
  logic [FRAME_BITS-1:0] next_sh;
  logic                  take_bit;

  assign take_bit = ev_rise & active;
  assign next_sh  = {shreg[FRAME_BITS-2:0], sda_f};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg       <= '0;
      bit_cnt     <= '0;
      frame_valid <= 1'b0;
      frame_data  <= '0;
      trunc_err   <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      trunc_err   <= 1'b0;
      if (ev_cond) begin
        // one stray bit from the rise before the condition is normal
        trunc_err <= (bit_cnt > CNT_W'(1));
        bit_cnt   <= '0;
      end else if (take_bit) begin
        shreg <= next_sh;
        if (bit_cnt == LAST) begin
          frame_valid <= 1'b1;
          frame_data  <= next_sh;
          bit_cnt     <= '0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_listen_monitor.sv
module i2c_listen_monitor
  import i2c_mon_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_drive_low,
  output logic       sda_drive_low,
  output logic       cond_pulse,
  output logic [1:0] cond_kind,
  output logic       frame_valid,
  output logic [8:0] frame_data,
  output logic       frame_first,
  output logic       frame_ack,
  output logic       frame_hdr10,
  output logic       frame_addr_lo,
  output logic       trunc_err
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  // bus outputs permanently released
  assign scl_drive_low = 1'b0;
  assign sda_drive_low = 1'b0;

  logic [1:0] raw_lines;
  logic [1:0] filt_lines;
  assign raw_lines = {scl_in, sda_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    mon_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_in  (raw_lines[g]),
      .line_out (filt_lines[g])
    );
  end

  logic scl_f, sda_f;
  assign sda_f = filt_lines[0];
  assign scl_f = filt_lines[1];

  logic ev_start, ev_stop, ev_rise, ev_cond;

  mon_cond_detect u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .ev_rise  (ev_rise)
  );
  assign ev_cond = ev_start | ev_stop;

  logic             bus_busy;
  logic [CNT_W-1:0] bit_cnt;
  logic [8:0]       sh_data;
  logic             sh_valid;

  mon_frame_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_rise     (ev_rise),
    .ev_cond     (ev_cond),
    .active      (bus_busy),
    .sda_f       (sda_f),
    .frame_valid (sh_valid),
    .frame_data  (sh_data),
    .bit_cnt     (bit_cnt),
    .trunc_err   (trunc_err)
  );

  logic  first_pend;
  logic  hdr_prev;
  cond_e kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_busy   <= 1'b0;
      cond_pulse <= 1'b0;
      kind_q     <= COND_NONE;
      first_pend <= 1'b0;
      hdr_prev   <= 1'b0;
    end else begin
      cond_pulse <= ev_cond;
      kind_q     <= COND_NONE;
      if (ev_start) begin
        kind_q     <= start_kind(bus_busy);
        bus_busy   <= 1'b1;
        first_pend <= 1'b1;
        hdr_prev   <= 1'b0;
      end else if (ev_stop) begin
        kind_q     <= COND_STOP;
        bus_busy   <= 1'b0;
        first_pend <= 1'b0;
        hdr_prev   <= 1'b0;
      end else if (sh_valid) begin
        first_pend <= 1'b0;
        hdr_prev   <= is_ten_bit_hdr(sh_data, first_pend);
      end
    end
  end

  assign cond_kind     = kind_q;
  assign frame_valid   = sh_valid;
  assign frame_data    = sh_data;
  assign frame_first   = sh_valid & first_pend;
  assign frame_ack     = sh_valid & ack_of(sh_data);
  assign frame_hdr10   = sh_valid & is_ten_bit_hdr(sh_data, first_pend);
  assign frame_addr_lo = sh_valid & hdr_prev & ~first_pend;
endmodule

// File: rtl/i2c_listen_monitor_chk.sv
module i2c_listen_monitor_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_start,
  input logic             ev_stop,
  input logic             ev_rise,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             bus_busy,
  input logic             cond_pulse,
  input logic             frame_valid,
  input logic             frame_first,
  input logic             frame_hdr10,
  input logic             frame_addr_lo,
  input logic             trunc_err
);
  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_start, ev_stop, ev_rise})); // R2
  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start || ev_stop) |=> (bit_cnt == '0)); // R4
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < CNT_W'(9)); // R3
  AST_FRAME_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(ev_rise)); // R3
  AST_NO_IDLE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(bus_busy)); // R8
  AST_TRUNC_WITH_COND: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_err |-> cond_pulse); // R6
  AST_HDR_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    frame_hdr10 |-> (frame_first && frame_valid)); // R7
  AST_LOW_NOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    frame_addr_lo |-> !frame_first); // R7
endmodule

bind i2c_listen_monitor i2c_listen_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ev_start      (ev_start),
  .ev_stop       (ev_stop),
  .ev_rise       (ev_rise),
  .bit_cnt       (bit_cnt),
  .bus_busy      (bus_busy),
  .cond_pulse    (cond_pulse),
  .frame_valid   (frame_valid),
  .frame_first   (frame_first),
  .frame_hdr10   (frame_hdr10),
  .frame_addr_lo (frame_addr_lo),
  .trunc_err     (trunc_err)
);

// File: tb/i2c_listen_monitor_bench.sv
`timescale 1ns/1ps
module i2c_listen_monitor_bench;
  localparam int HP  = 10;   // half bit phase in system clocks
  localparam int GAP = 5;    // shortest STOP-to-START spacing

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  always #10 clk = ~clk;

  logic       scl_drive_low, sda_drive_low, cond_pulse, frame_valid;
  logic [1:0] cond_kind;
  logic [8:0] frame_data;
  logic       frame_first, frame_ack, frame_hdr10, frame_addr_lo, trunc_err;

  i2c_listen_monitor u_i2c_listen_monitor (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_drv),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .cond_pulse(cond_pulse), .cond_kind(cond_kind),
    .frame_valid(frame_valid), .frame_data(frame_data),
    .frame_first(frame_first), .frame_ack(frame_ack),
    .frame_hdr10(frame_hdr10), .frame_addr_lo(frame_addr_lo),
    .trunc_err(trunc_err)
  );

  int total = 0;
  int bad = 0;
  int drive_bad = 0;
  logic done = 1'b0;
  string cur_req = "R10";

  logic [15:0] exp_q [0:2047];
  int exp_wr = 0;
  int exp_rd = 0;

  // model state
  logic tb_busy = 1'b0;
  logic tb_first = 1'b0;
  logic tb_hdr_prev = 1'b0;
  int   tb_bits = 0;

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic observe(input logic [15:0] w);
    if (exp_rd >= exp_wr) begin
      total++; bad++;
      $display("FAIL %s unexpected event got=%h exp=none", cur_req, w);
    end else begin
      check(cur_req, w, exp_q[exp_rd]);
      exp_rd++;
    end
  endtask

  always @(negedge clk) begin
    if (scl_drive_low !== 1'b0 || sda_drive_low !== 1'b0) drive_bad++;
    if (rst_n) begin
      if (trunc_err) observe(16'hA000);
      if (cond_pulse) observe({1'b0, cond_kind, 13'd0});
      if (frame_valid)
        observe({3'd4, frame_hdr10, frame_addr_lo, frame_first, frame_ack, frame_data});
    end
  end

  task automatic push(input logic [15:0] w);
    exp_q[exp_wr] = w;
    exp_wr++;
  endtask

  task automatic half();
    repeat (HP) @(negedge clk);
  endtask

  task automatic do_start();
    if (tb_busy) begin
      if (tb_bits >= 1) push(16'hA000);
      push(16'h4000);               // repeated START, kind 2
      sda_drv = 1'b1; half();
      scl_drv = 1'b1; half();
    end else begin
      push(16'h2000);               // START, kind 1
    end
    sda_drv = 1'b0; half();
    scl_drv = 1'b0;
    tb_busy = 1'b1; tb_first = 1'b1; tb_hdr_prev = 1'b0; tb_bits = 0;
  endtask

  task automatic do_stop(input int gap);
    if (tb_bits >= 1) push(16'hA000);
    push(16'h6000);                 // STOP, kind 3
    sda_drv = 1'b0; half();
    scl_drv = 1'b1; half();
    sda_drv = 1'b1;
    repeat (gap) @(negedge clk);
    tb_busy = 1'b0; tb_bits = 0;
  endtask

  // glitch: 0 none, 1 short SCL pulse in low phase, 2 short SDA dip in high phase
  task automatic send_bit(input logic b, input int glitch);
    sda_drv = b;
    if (glitch == 1) begin
      repeat (3) @(negedge clk);
      scl_drv = 1'b1; @(negedge clk); scl_drv = 1'b0;
      repeat (HP - 4) @(negedge clk);
    end else half();
    scl_drv = 1'b1;
    if (glitch == 2 && b) begin
      repeat (3) @(negedge clk);
      sda_drv = 1'b0; repeat (2) @(negedge clk); sda_drv = 1'b1;
      repeat (HP - 5) @(negedge clk);
    end else half();
    scl_drv = 1'b0;
    tb_bits++;
  endtask

  task automatic send_frame(input logic [7:0] byt, input logic ninth, input int glitch);
    logic hdr, lo;
    hdr = tb_first && (byt[7:3] == 5'b11110);
    lo  = tb_hdr_prev && !tb_first;
    push({3'd4, hdr, lo, tb_first, ~ninth, byt, ninth});
    for (int i = 7; i >= 0; i--) send_bit(byt[i], glitch);
    send_bit(ninth, glitch);
    tb_first = 1'b0; tb_hdr_prev = hdr; tb_bits = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state of every output
    check("R10", {3'd0, cond_pulse, cond_kind, frame_valid, frame_data},
          16'h0000);
    check("R10", {12'd0, frame_first, frame_ack, frame_hdr10, frame_addr_lo | trunc_err},
          16'h0000);
    repeat (10) @(negedge clk);

    // R3 R5: 7-bit address sweep with varying direction and acknowledge
    cur_req = "R3/R5";
    for (int a = 0; a < 128; a++) begin
      logic [7:0] ab;
      ab = {a[6:0], a[0] ^ a[1]};
      do_start();
      send_frame(ab, a[2], 0);
      do_stop(HP);
    end

    // R2 R3: data patterns and a repeated START for a read
    cur_req = "R2/R3";
    for (int p = 0; p < 8; p++) begin
      do_start();
      send_frame(8'hA0 | 8'(p << 1), 1'b0, 0);
      send_frame(8'(p * 37 + 5), p[0], 0);
      send_frame(~8'(p * 37 + 5), 1'b0, 0);
      do_start();
      send_frame(8'hA1 | 8'(p << 1), 1'b0, 0);
      send_frame(8'h5A ^ 8'(p), 1'b1, 0);
      do_stop(HP);
    end

    // R7: 10-bit headers, low address byte, and a repeated header for a read
    cur_req = "R7";
    for (int h = 0; h < 8; h++) begin
      do_start();
      send_frame({5'b11110, h[1:0], h[2]}, 1'b0, 0);
      send_frame(8'(h * 29), 1'b0, 0);
      send_frame(8'hC3, 1'b0, 0);
      do_start();
      send_frame({5'b11110, h[1:0], 1'b1}, 1'b0, 0);
      send_frame(8'h3C, 1'b1, 0);
      do_stop(HP);
    end

    // R4: STOP followed at once by START, repeated back to back
    cur_req = "R4";
    for (int k = 0; k < 6; k++) begin
      do_start();
      send_frame(8'h90 + 8'(k), 1'b0, 0);
      send_frame(8'hFF, 1'b1, 0);
      do_stop(GAP);
    end
    do_start();
    send_frame(8'h3E, 1'b0, 0);
    do_stop(HP);

    // R6: aborted frame with four bits then STOP, next transfer aligned
    cur_req = "R6";
    do_start();
    send_frame(8'h42, 1'b0, 0);
    for (int i = 0; i < 4; i++) send_bit(i[0], 0);
    do_stop(GAP);
    do_start();
    for (int i = 0; i < 3; i++) send_bit(1'b1, 0);
    do_start();                     // repeated START drops three bits
    send_frame(8'h81, 1'b0, 0);
    do_stop(HP);

    // R8: SCL toggles while idle produce nothing
    cur_req = "R8";
    for (int i = 0; i < 11; i++) begin
      scl_drv = 1'b0; half();
      scl_drv = 1'b1; half();
    end
    do_start();
    send_frame(8'h6C, 1'b0, 0);
    do_stop(HP);

    // R9: short glitches on SCL and SDA inside frames
    cur_req = "R9";
    do_start();
    send_frame(8'hB7, 1'b0, 1);
    send_frame(8'hFF, 1'b1, 2);
    send_frame(8'h2D, 1'b0, 1);
    do_stop(HP);

    repeat (40) @(negedge clk);
    check("R1", 16'(drive_bad), 16'd0);
    check("R3", 16'(exp_wr - exp_rd), 16'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL %s watchdog got=running exp=finished", cur_req);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule